// File: doc/BRIEF.md
# Frame-Synchronised Endpoint Receive Buffer

This block buffers received packets for one endpoint of a USB device controller. The packet engine delivers each packet as a byte stream. A packet whose last beat carries a good-check indication becomes a data set. The block keeps each set's length in a small queue and reports how many sets firmware can see as a two-bit index. Firmware reads the bytes of the oldest visible set through a byte port. It reads the remaining count with a count-read strobe and retires the set with a read-complete strobe. Retiring a set skips any bytes that were not read.

In isochronous mode a completed set stays hidden until the next start-of-frame (SOF) pulse. The set that was visible during a frame must be retired before the following SOF. If it is not, hardware drops it at that SOF and raises a flush flag. While the flush flag is up, the data port is inert. Firmware then asserts read-complete, which clears the flag without retiring anything else. Status that firmware causes (reads, underrun) changes at once. Status that USB traffic causes changes only at SOF.

Reading past the end of a set, or reading the count while no set is visible, raises a sticky underrun flag. That flag freezes the read position and makes the block NACK every packet until an explicit clear.

Top module: `rxset_fifo`

## Requirements
- R1: After reset `empty` is 1; `full`, `underrun`, `flush` and `nack` are 0; `set_idx` and `byte_cnt` are 0.
- R2: In non-isochronous mode, a packet of N bytes with `in_ok`=1 on its last beat makes `set_idx` rise by one on the edge that takes the last beat. When it becomes the current set, `byte_cnt` shows N and `rd_data` shows its bytes in arrival order, one per `fw_rd` pulse.
- R3: In isochronous mode a completed set does not change `set_idx`, `byte_cnt` or `empty` until the next `sof` pulse, after which it is visible.
- R4: In isochronous mode, a `sof` that arrives while a set is visible and `rd_done` is not asserted drops the current set. It decrements the index, sets `flush`, and makes visible any sets completed during the frame.
- R5: While `flush` is 1, `fw_rd` changes neither `byte_cnt` nor `underrun`. `rd_done` clears `flush` and retires no set.
- R6: `full` is 1 exactly when the current set holds 64 unread bytes, with `byte_cnt` = 64. `empty` is 1 exactly when `byte_cnt` is 0.
- R7: `fw_rd` while `empty`=1 (and `flush`=0), or `cnt_rd` while `set_idx`=0, sets `underrun`. It stays set until `clr`, and while it is set `fw_rd` does not change `byte_cnt`.
- R8: While `underrun` is 1, `nack` is 1 and an arriving packet stores nothing.
- R9: `set_idx` saturates at 3. A packet that starts while three sets are held is dropped, and `nack` is 1 for the one cycle after its last beat.
- R10: A packet that does not fit in the free space of the 64-byte store is dropped whole, with the same one-cycle `nack`.
- R11: A `clr` pulse empties the store in one cycle: the next cycle shows `set_idx`=0, `byte_cnt`=0, `empty`=1, `underrun`=0 and `flush`=0.
- R12: A packet whose last beat has `in_ok`=0 is discarded silently. It stores no set and raises no `nack`.
- R13: `in_ready` is 1 in every cycle except one in which `clr` is asserted. The block never holds back the packet stream for any other reason; overflow is handled by dropping (R9, R10).
- R14: `rd_done` retires the current set even if it is partly read. The next set's first byte then appears on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iso_mode | input | 1 | 1 selects frame-synchronised (isochronous) handling |
| sof | input | 1 | Start-of-frame pulse |
| clr | input | 1 | Clear pulse: empties store, index, underrun and flush |
| in_valid | input | 1 | Packet byte valid |
| in_ready | output | 1 | Packet byte accepted when high together with in_valid |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ok | input | 1 | Packet passed its checks; sampled with in_last |
| fw_rd | input | 1 | Firmware byte-read pulse |
| rd_data | output | 8 | Byte at the read position of the current set |
| cnt_rd | input | 1 | Firmware read of the byte count |
| rd_done | input | 1 | Firmware read-complete pulse |
| set_idx | output | 2 | Number of sets visible to firmware |
| byte_cnt | output | 7 | Unread bytes in the current set |
| empty | output | 1 | Current set has no unread bytes |
| full | output | 1 | Current set holds the whole store, unread |
| underrun | output | 1 | Sticky underrun flag |
| flush | output | 1 | A set was dropped at SOF; data port blocked |
| nack | output | 1 | Request to answer the host with NACK |

## Verification
The assertions assume that `sof`, `clr`, `rd_done`, `fw_rd` and `cnt_rd` are single-cycle pulses. They also assume that `in_last` and `in_ok` carry meaning only on an accepted beat and that packets do not overlap. The stimulus drives every input on the falling edge. It raises each strobe for exactly one cycle and sends a packet as consecutive beats with `in_last` only on the final one. It never mixes a `clr` with a packet beat, because `in_ready` is low then. No SOF and read-complete coincide in the stimulus, so the same-cycle rule is left to the properties.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef logic [7:0] byte_t;

  typedef struct packed {
    logic empty;
    logic full;
    logic underrun;
    logic flush;
  } rx_flags_t;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  byte_t         wdata,
  input  logic [AW-1:0] raddr,
  output byte_t         rdata
);
  byte_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/rxf_wr.sv
// Packet ingest: writes bytes speculatively past the committed write pointer
// and commits the whole packet only on a good last beat.
module rxf_wr
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  byte_t         in_data,
  input  logic          in_last,
  input  logic          in_ok,
  input  logic [PW-1:0] rbase,
  input  logic          sets_full,
  input  logic          block,
  output logic          we,
  output logic [PW-2:0] waddr,
  output byte_t         wdata,
  output logic          commit,
  output logic [PW-1:0] commit_len,
  output logic          reject_q
);
  logic [PW-1:0] wptr, spec, used, fill, wa_full;
  logic          in_pkt, drop, beat, drop_now;

  assign in_ready = ~clr;
  assign beat     = in_valid & in_ready;
  assign used     = wptr - rbase;
  assign fill     = used + spec;
  assign drop_now = drop | (~in_pkt & (sets_full | block)) | (fill >= PW'(DEPTH));

  assign wa_full    = wptr + spec;
  assign waddr      = wa_full[PW-2:0];
  assign wdata      = in_data;
  assign we         = beat & ~drop_now;
  assign commit     = beat & in_last & in_ok & ~drop_now;
  assign commit_len = spec + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      spec     <= '0;
      in_pkt   <= 1'b0;
      drop     <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= beat & in_last & in_ok & drop_now;
      if (clr) begin
        wptr <= '0;
        spec <= '0;
        drop <= in_pkt;
      end else if (beat) begin
        if (in_last) begin
          spec   <= '0;
          in_pkt <= 1'b0;
          drop   <= 1'b0;
          if (commit) wptr <= wptr + commit_len;
        end else begin
          spec   <= spec + (we ? PW'(1) : PW'(0));
          in_pkt <= 1'b1;
          drop   <= drop_now;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_setq.sv
// Queue of committed set lengths with visible/pending split and SOF handling.
module rxf_setq #(
  parameter int IDX_MAX = 3,
  parameter int LW      = 7,
  parameter int IW      = $clog2(IDX_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          iso,
  input  logic          sof,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          pop_req,
  output logic [LW-1:0] head_len,
  output logic [IW-1:0] vis,
  output logic          sets_full,
  output logic          pop_any,
  output logic          sof_drop
);
  localparam int QN = 1 << IW;

  logic [LW-1:0] lenq [QN];
  logic [IW-1:0] hp, tp, total, total_n, vis_n;
  logic          pop;

  assign pop       = pop_req & (vis != '0);
  assign sof_drop  = iso & sof & (vis != '0) & ~pop;
  assign pop_any   = pop | sof_drop;
  assign sets_full = (total == IW'(IDX_MAX));
  assign head_len  = lenq[hp];
  assign total_n   = total + IW'(push) - IW'(pop_any);

  always_comb begin
    if (!iso)     vis_n = total_n;
    else if (sof) vis_n = total - IW'(pop_any);
    else          vis_n = vis - IW'(pop_any);
  end

  always_ff @(posedge clk) begin
    if (push && !clr) lenq[tp] <= push_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp    <= '0;
      tp    <= '0;
      total <= '0;
      vis   <= '0;
    end else if (clr) begin
      hp    <= '0;
      tp    <= '0;
      total <= '0;
      vis   <= '0;
    end else begin
      if (push)    tp <= tp + IW'(1);
      if (pop_any) hp <= hp + IW'(1);
      total <= total_n;
      vis   <= vis_n;
    end
  end
endmodule

// File: rtl/rxset_fifo.sv
module rxset_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int IDX_MAX = 3,
  parameter int PW      = $clog2(DEPTH) + 1,
  parameter int IW      = $clog2(IDX_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iso_mode,
  input  logic          sof,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_ok,
  input  logic          fw_rd,
  output logic [7:0]    rd_data,
  input  logic          cnt_rd,
  input  logic          rd_done,
  output logic [IW-1:0] set_idx,
  output logic [PW-1:0] byte_cnt,
  output logic          empty,
  output logic          full,
  output logic          underrun,
  output logic          flush,
  output logic          nack
);
  localparam int AW = PW - 1;

  logic [PW-1:0] rbase, rd_off, head_len, cur_len, commit_len, raddr_full;
  logic [AW-1:0] waddr;
  logic [IW-1:0] vis;
  logic          we, commit, reject_q, sets_full, pop_any, sof_drop;
  logic          rd_ok, urf_set;
  byte_t         wdata;
  rx_flags_t     fl_q;

  rxf_wr #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .clk, .rst_n, .clr, .in_valid, .in_ready, .in_data, .in_last, .in_ok,
    .rbase, .sets_full, .block(fl_q.underrun), .we, .waddr, .wdata,
    .commit, .commit_len, .reject_q
  );

  rxf_setq #(.IDX_MAX(IDX_MAX), .LW(PW), .IW(IW)) u_setq (
    .clk, .rst_n, .clr, .iso(iso_mode), .sof, .push(commit),
    .push_len(commit_len), .pop_req(rd_done & ~fl_q.flush),
    .head_len, .vis, .sets_full, .pop_any, .sof_drop
  );

  assign raddr_full = rbase + rd_off;

  rxf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk, .we, .waddr, .wdata, .raddr(raddr_full[AW-1:0]), .rdata(rd_data)
  );

  // Current-set view
  assign cur_len  = (vis != '0) ? head_len : '0;
  assign byte_cnt = cur_len - rd_off;
  assign empty    = (rd_off == cur_len);
  assign full     = (vis != '0) && (rd_off == '0) && (head_len == PW'(DEPTH));

  assign rd_ok   = fw_rd & ~fl_q.flush & ~fl_q.underrun & ~empty;
  assign urf_set = (fw_rd & ~fl_q.flush & empty) | (cnt_rd & (vis == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbase  <= '0;
      rd_off <= '0;
      fl_q   <= '0;
    end else if (clr) begin
      rbase  <= '0;
      rd_off <= '0;
      fl_q   <= '0;
    end else begin
      if (pop_any) begin
        rbase  <= rbase + head_len;
        rd_off <= '0;
      end else if (rd_ok) begin
        rd_off <= rd_off + PW'(1);
      end
      fl_q.underrun <= fl_q.underrun | urf_set;
      if (sof_drop)     fl_q.flush <= 1'b1;
      else if (rd_done) fl_q.flush <= 1'b0;
    end
  end

  assign set_idx  = vis;
  assign underrun = fl_q.underrun;
  assign flush    = fl_q.flush;
  assign nack     = fl_q.underrun | reject_q;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int DEPTH = 64,
  parameter int PW    = 7,
  parameter int IW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iso_mode,
  input logic          sof,
  input logic          clr,
  input logic          fw_rd,
  input logic          rd_done,
  input logic [IW-1:0] set_idx,
  input logic [PW-1:0] byte_cnt,
  input logic          empty,
  input logic          full,
  input logic          underrun,
  input logic          flush,
  input logic          nack
);
  p_iso_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_mode && !sof && !clr) |=> (set_idx <= $past(set_idx)));

  p_sof_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_mode && sof && set_idx != '0 && !rd_done && !clr) |=> flush);

  p_flush_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fw_rd && !rd_done && !sof && !clr) |=> $stable(byte_cnt));

  p_full_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (byte_cnt == PW'(DEPTH)));

  p_empty_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (byte_cnt == '0));

  p_urf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clr) |=> underrun);

  p_nack_urf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> nack);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && set_idx == '0 && !underrun && !flush));
endmodule

bind rxset_fifo rxf_chk #(.DEPTH(DEPTH), .PW(PW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iso_mode(iso_mode), .sof(sof), .clr(clr),
  .fw_rd(fw_rd), .rd_done(rd_done), .set_idx(set_idx), .byte_cnt(byte_cnt),
  .empty(empty), .full(full), .underrun(underrun), .flush(flush), .nack(nack)
);

// File: tb/sim_rxset_fifo.sv
module sim_rxset_fifo;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       iso_mode = 0, sof = 0, clr = 0, in_valid = 0, in_last = 0, in_ok = 0;
  logic       fw_rd = 0, cnt_rd = 0, rd_done = 0;
  logic [7:0] in_data = '0;
  logic       in_ready, empty, full, underrun, flush, nack;
  logic [7:0] rd_data;
  logic [1:0] set_idx;
  logic [6:0] byte_cnt;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rxset_fifo u0 (.*);

  localparam logic [2:0] PKT = 0, BAD = 1, RD = 2, DONE = 3, SOF = 4, CLR = 5, CNT = 6, ISO = 7;

  typedef struct packed {
    logic [2:0] op;
    logic [6:0] arg;
    logic [3:0] req;
    logic [1:0] idx;
    logic [6:0] cnt;
    logic [3:0] fl;  // {empty, full, underrun, flush}
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{PKT,  7'd5,  4'd2,  2'd1, 7'd5,  4'b0000},  // R2
    '{PKT,  7'd3,  4'd2,  2'd2, 7'd5,  4'b0000},  // R2
    '{RD,   7'd2,  4'd2,  2'd2, 7'd3,  4'b0000},  // R2
    '{DONE, 7'd0,  4'd14, 2'd1, 7'd3,  4'b0000},  // R14
    '{RD,   7'd3,  4'd6,  2'd1, 7'd0,  4'b1000},  // R6
    '{RD,   7'd1,  4'd7,  2'd1, 7'd0,  4'b1010},  // R7
    '{PKT,  7'd4,  4'd8,  2'd1, 7'd0,  4'b1010},  // R8
    '{CLR,  7'd0,  4'd11, 2'd0, 7'd0,  4'b1000},  // R11
    '{CNT,  7'd0,  4'd7,  2'd0, 7'd0,  4'b1010},  // R7
    '{CLR,  7'd0,  4'd11, 2'd0, 7'd0,  4'b1000},  // R11
    '{PKT,  7'd64, 4'd6,  2'd1, 7'd64, 4'b0100},  // R6
    '{PKT,  7'd1,  4'd10, 2'd1, 7'd64, 4'b0100},  // R10
    '{RD,   7'd1,  4'd6,  2'd1, 7'd63, 4'b0000},  // R6
    '{DONE, 7'd0,  4'd14, 2'd0, 7'd0,  4'b1000},  // R14
    '{ISO,  7'd1,  4'd3,  2'd0, 7'd0,  4'b1000},  // R3
    '{PKT,  7'd6,  4'd3,  2'd0, 7'd0,  4'b1000},  // R3
    '{SOF,  7'd0,  4'd3,  2'd1, 7'd6,  4'b0000},  // R3
    '{RD,   7'd2,  4'd3,  2'd1, 7'd4,  4'b0000},  // R3
    '{PKT,  7'd2,  4'd3,  2'd1, 7'd4,  4'b0000},  // R3
    '{SOF,  7'd0,  4'd4,  2'd1, 7'd2,  4'b0001},  // R4
    '{RD,   7'd1,  4'd5,  2'd1, 7'd2,  4'b0001},  // R5
    '{DONE, 7'd0,  4'd5,  2'd1, 7'd2,  4'b0000},  // R5
    '{DONE, 7'd0,  4'd14, 2'd0, 7'd0,  4'b1000},  // R14
    '{BAD,  7'd3,  4'd12, 2'd0, 7'd0,  4'b1000},  // R12
    '{SOF,  7'd0,  4'd12, 2'd0, 7'd0,  4'b1000},  // R12
    '{ISO,  7'd0,  4'd2,  2'd0, 7'd0,  4'b1000},  // R2
    '{PKT,  7'd1,  4'd9,  2'd1, 7'd1,  4'b0000},  // R9
    '{PKT,  7'd1,  4'd9,  2'd2, 7'd1,  4'b0000},  // R9
    '{PKT,  7'd1,  4'd9,  2'd3, 7'd1,  4'b0000},  // R9
    '{PKT,  7'd1,  4'd9,  2'd3, 7'd1,  4'b0000}   // R9
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input logic ok, input logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = base + 8'(i); in_last = (i == len - 1); in_ok = ok;
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_ok = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) pulse(fw_rd);
  endtask

  function automatic int state_word();
    return {set_idx, byte_cnt, empty, full, underrun, flush};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 flags", {empty, full, underrun, flush, nack}, 5'b10000);
    chk("R1 idx/cnt", {set_idx, byte_cnt}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      case (TBL[v].op)
        PKT:  send_pkt(int'(TBL[v].arg), 1'b1, 8'h10);
        BAD:  send_pkt(int'(TBL[v].arg), 1'b0, 8'h20);
        RD:   read_n(int'(TBL[v].arg));
        DONE: pulse(rd_done);
        SOF:  pulse(sof);
        CLR:  pulse(clr);
        CNT:  pulse(cnt_rd);
        ISO:  begin @(negedge clk); iso_mode = TBL[v].arg[0]; @(negedge clk); end
        default: ;
      endcase
      chk($sformatf("R%0d vector %0d", TBL[v].req, v), state_word(),
          {TBL[v].idx, TBL[v].cnt, TBL[v].fl});
    end

    // R9: saturated index, next packet drops with a one-cycle nack
    send_pkt(1, 1'b1, 8'h30);
    chk("R9 nack pulse", nack, 1);
    @(negedge clk);
    chk("R9 nack ends", nack, 0);
    chk("R9 idx held", set_idx, 3);

    // R13: in_ready low only during clr
    chk("R13 ready idle", in_ready, 1);
    @(negedge clk); clr = 1; #1;
    chk("R13 ready in clr", in_ready, 0);
    @(negedge clk); clr = 0;
    chk("R11 cleared", state_word(), {2'd0, 7'd0, 4'b1000});

    // R2 / R14: byte order and skip on read-complete
    send_pkt(3, 1'b1, 8'hA0);
    send_pkt(2, 1'b1, 8'hB0);
    chk("R2 first byte", rd_data, 8'hA0);
    read_n(1);
    chk("R2 second byte", rd_data, 8'hA1);
    pulse(rd_done);
    chk("R14 next set byte", rd_data, 8'hB0);
    chk("R14 next set cnt", byte_cnt, 2);

    // R10: oversize packet against partly filled store
    send_pkt(63, 1'b1, 8'h00);
    chk("R10 nack pulse", nack, 1);
    chk("R10 idx", set_idx, 1);

    // R8: underrun forces nack and blocks storing; R7 frozen pointer
    pulse(clr);
    pulse(cnt_rd);
    chk("R8 nack level", nack, 1);
    send_pkt(2, 1'b1, 8'h40);
    @(negedge clk);
    chk("R8 nothing stored", set_idx, 0);
    chk("R8 nack held", nack, 1);
    read_n(2);
    chk("R7 frozen cnt", byte_cnt, 0);
    pulse(clr);
    chk("R7 cleared only by clr", underrun, 0);

    // R12: bad packet raises no nack
    send_pkt(2, 1'b0, 8'h50);
    chk("R12 no nack", nack, 0);
    chk("R12 not stored", set_idx, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule